// File: doc/BRIEF.md
# Streaming Merge Sorter

This block sorts a stream of keys in sets of N. It takes one unsorted key per clock cycle and produces one sorted key per clock cycle. Internally it is a chain of log2(N) merge stages. Stage k takes in runs of length 2^k that are already sorted and merges each pair of them into one sorted run of length 2^(k+1). The last stage therefore emits each set of N keys as one fully sorted run.

Each stage has two buffers. Run A of a pair goes into buffer 0 and run B goes into buffer 1. The stage starts merging once all of run A is in buffer 0 and the first key of run B has reached buffer 1. From then on it compares the two buffer heads and forwards the smaller one. When one run runs out, the stage sends the rest of the other run without comparing. Each buffer holds twice the stage's run length, so the storage doubles from stage to stage towards the output.

Only the upper SORT_W bits of a key set its order. The lower bits are payload that travels with the key. When two keys have equal order fields, the earlier one goes out first, so the sort is stable. The output marks the last key of every sorted set.

Top module: `stream_merge_sorter`

## Requirements
- R1: While rst_n is low, in_ready and out_valid are 0. From the first clock edge after reset is released, in_ready is 1 and stays 1.
- R2: Each set of N consecutive accepted keys comes out as a permutation of itself, ordered by the order field key[KEY_W-1:KEY_W-SORT_W] from smallest to largest.
- R3: Keys with equal order fields come out in the order they were accepted.
- R4: out_last is 1 on the N-th key of each sorted set (output positions N-1, 2N-1, and so on) and 0 on every other output.
- R5: When whole sets are fed with no gaps, the output is also gap-free: once output starts, out_valid stays 1 for every key of all those sets.
- R6: Latency is fixed. If the first key of a set is accepted at clock edge e, its first sorted key is registered on out_valid at edge e + N + 2*log2(N) - 2.
- R7: Idle cycles in the input (in_valid low between keys) do not change the sorted result or the positions of out_last.
- R8: A stage never writes to a full buffer and never reads from an empty one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input key is valid |
| in_ready | output | 1 | Sorter accepts a key in this cycle |
| in_key | input | KEY_W | Unsorted key: order field in the upper bits, payload below |
| out_valid | output | 1 | Sorted key is valid |
| out_key | output | KEY_W | Sorted key |
| out_last | output | 1 | Marks the last key of a sorted set |

## Verification
The bench builds the sorter with N = 16, KEY_W = 16 and SORT_W = 8. This gives a chain of four stages with run lengths 1, 2, 4 and 8, so the first stage (pairs of single keys) and the widest stage both run in every test. The 8-bit payload carries each key's arrival index, which lets the bench see whether equal-keyed entries kept their order. Sets are fed back to back and also with idle gaps. The inputs cover ascending, descending, scattered and heavily tied order fields, so both the compare path and the drain-without-compare path are exercised, and the cycle counts of R5 and R6 are checked.

// File: rtl/msort_pkg.sv
package msort_pkg;
    // which buffer head a merge stage forwards in a cycle
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_0    = 2'd1,
        PICK_1    = 2'd2
    } pick_e;
endpackage

// File: rtl/msort_fifo.sv
module msort_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_q, p_d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        p_d = p_q;
        if (push) p_d.wr = (p_q.wr == PW'(DEPTH - 1)) ? '0 : p_q.wr + PW'(1);
        if (pop)  p_d.rd = (p_q.rd == PW'(DEPTH - 1)) ? '0 : p_q.rd + PW'(1);
        case ({push, pop})
            2'b10:   p_d.cnt = p_q.cnt + CW'(1);
            2'b01:   p_d.cnt = p_q.cnt - CW'(1);
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[p_q.wr] <= wdata;
    end

    assign head  = mem[p_q.rd];
    assign count = p_q.cnt;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (p_q.cnt < CW'(DEPTH)));
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (p_q.cnt != '0));
endmodule

// File: rtl/msort_stage.sv
module msort_stage
    import msort_pkg::*;
#(
    parameter int KEY_W  = 16,
    parameter int SORT_W = 8,
    parameter int RUN    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key
);
    localparam int DEPTH = 2 * RUN;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int RW    = $clog2(RUN) + 1;
    localparam int IW    = (RUN > 1) ? $clog2(RUN) : 1;

    typedef struct packed {
        logic [RW-1:0]    rem0;
        logic [RW-1:0]    rem1;
        logic             wsel;
        logic [IW-1:0]    wcnt;
        logic             ovalid;
        logic [KEY_W-1:0] okey;
    } st_t;

    st_t s_q, s_d;

    logic             push0, push1, pop0, pop1;
    logic [KEY_W-1:0] head0, head1;
    logic [CW-1:0]    cnt0, cnt1;
    logic             start;
    logic [RW-1:0]    r0, r1;
    pick_e            pick;

    msort_fifo #(.W(KEY_W), .DEPTH(DEPTH)) u_buf0 (
        .clk(clk), .rst_n(rst_n), .push(push0), .wdata(in_key),
        .pop(pop0), .head(head0), .count(cnt0)
    );
    msort_fifo #(.W(KEY_W), .DEPTH(DEPTH)) u_buf1 (
        .clk(clk), .rst_n(rst_n), .push(push1), .wdata(in_key),
        .pop(pop1), .head(head1), .count(cnt1)
    );

    always_comb begin
        s_d   = s_q;
        push0 = 1'b0;
        push1 = 1'b0;
        pop0  = 1'b0;
        pop1  = 1'b0;
        pick  = PICK_NONE;

        // write side: runs alternate between the two buffers
        if (in_valid) begin
            if (s_q.wsel) push1 = 1'b1;
            else          push0 = 1'b1;
            if (s_q.wcnt == IW'(RUN - 1)) begin
                s_d.wcnt = '0;
                s_d.wsel = ~s_q.wsel;
            end else begin
                s_d.wcnt = s_q.wcnt + IW'(1);
            end
        end

        // a pair starts once run A is complete and run B has begun
        start = (s_q.rem0 == '0) && (s_q.rem1 == '0)
              && (cnt0 >= CW'(RUN)) && (cnt1 != '0);
        r0 = start ? RW'(RUN) : s_q.rem0;
        r1 = start ? RW'(RUN) : s_q.rem1;

        if (r0 != '0 && r1 != '0) begin
            if (cnt1 != '0)
                pick = (head0[KEY_W-1 -: SORT_W] <= head1[KEY_W-1 -: SORT_W])
                     ? PICK_0 : PICK_1;
        end else if (r0 != '0) begin
            if (cnt0 != '0) pick = PICK_0;
        end else if (r1 != '0) begin
            if (cnt1 != '0) pick = PICK_1;
        end

        s_d.ovalid = 1'b0;
        case (pick)
            PICK_0: begin
                pop0       = 1'b1;
                r0         = r0 - RW'(1);
                s_d.ovalid = 1'b1;
                s_d.okey   = head0;
            end
            PICK_1: begin
                pop1       = 1'b1;
                r1         = r1 - RW'(1);
                s_d.ovalid = 1'b1;
                s_d.okey   = head1;
            end
            default: ;
        endcase
        s_d.rem0 = r0;
        s_d.rem1 = r1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ovalid;
    assign out_key   = s_q.okey;

    // R5
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rem0 == '0 && s_q.rem1 != '0 && cnt1 != '0) |=> s_q.ovalid);
endmodule

// File: rtl/stream_merge_sorter.sv
module stream_merge_sorter #(
    parameter int N      = 16,
    parameter int KEY_W  = 16,
    parameter int SORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key,
    output logic             out_last
);
    localparam int L  = $clog2(N);
    localparam int LW = (L > 0) ? L : 1;

    typedef struct packed {
        logic             ready;
        logic [LW-1:0]    ocnt;
        logic [KEY_W-1:0] prev;
    } top_t;

    top_t t_q, t_d;

    logic [L:0]       v;
    logic [KEY_W-1:0] kk [L+1];

    assign v[0]  = in_valid && t_q.ready;
    assign kk[0] = in_key;

    for (genvar g = 0; g < L; g++) begin : g_stage
        msort_stage #(.KEY_W(KEY_W), .SORT_W(SORT_W), .RUN(1 << g)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_valid(v[g]), .in_key(kk[g]),
            .out_valid(v[g+1]), .out_key(kk[g+1])
        );
    end

    always_comb begin
        t_d       = t_q;
        t_d.ready = 1'b1;
        if (v[L]) begin
            t_d.ocnt = t_q.ocnt + LW'(1);
            t_d.prev = kk[L];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign in_ready  = t_q.ready;
    assign out_valid = v[L];
    assign out_key   = kk[L];
    assign out_last  = v[L] && (t_q.ocnt == LW'(N - 1));

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);
    // R2
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && t_q.ocnt != '0)
        |-> (out_key[KEY_W-1 -: SORT_W] >= t_q.prev[KEY_W-1 -: SORT_W]));
endmodule

// File: tb/sim_stream_merge_sorter.sv
module sim_stream_merge_sorter;
    localparam int N     = 16;
    localparam int KW    = 16;
    localparam int SW    = 8;
    localparam int LAT   = N + 2 * $clog2(N) - 2;
    localparam int MAXK  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [KW-1:0] in_key = '0;
    logic out_valid;
    logic [KW-1:0] out_key;
    logic out_last;

    always #5 clk = ~clk;

    stream_merge_sorter #(.N(N), .KEY_W(KW), .SORT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .out_valid(out_valid), .out_key(out_key), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [KW-1:0] in_keys  [MAXK];
    int            in_cyc   [MAXK];
    logic [KW-1:0] out_keys [MAXK];
    logic          out_lst  [MAXK];
    int            out_cyc  [MAXK];
    int n_in = 0;
    int n_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid && n_out < MAXK) begin
            out_keys[n_out] = out_key;
            out_lst[n_out]  = out_last;
            out_cyc[n_out]  = cyc;
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [KW-1:0] gen_key(input int pat, input int i);
        int p;
        logic [7:0] sf;
        p = i % N;
        case (pat)
            0:       sf = 8'(p * 3 + 1);
            1:       sf = 8'(250 - p * 7);
            2:       sf = 8'((i * 73 + 29) % 61);
            default: sf = 8'(p % 3);
        endcase
        return {sf, 8'(i)};
    endfunction

    task automatic drive(input int nfr, input int pat, input bit gaps);
        n_in = 0;
        n_out = 0;
        for (int i = 0; i < nfr * N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_key   = gen_key(pat, i);
            @(posedge clk);
            #1;
            in_keys[n_in] = in_key;
            in_cyc[n_in]  = cyc;
            n_in++;
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (i % 4) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + N + 12) @(posedge clk);
        #2;
    endtask

    // compare collected output with a stable reference sort
    task automatic check_run(input int nfr, input string req, input bit tp, input bit lat);
        logic [KW-1:0] ex [N];
        chk(n_out == nfr * N, "R2 count", n_out, nfr * N);
        for (int f = 0; f < nfr; f++) begin
            for (int i = 0; i < N; i++) ex[i] = in_keys[f * N + i];
            for (int i = 1; i < N; i++) begin
                for (int j = i; j > 0; j--) begin
                    if (ex[j-1][KW-1 -: SW] > ex[j][KW-1 -: SW]) begin
                        logic [KW-1:0] t;
                        t = ex[j]; ex[j] = ex[j-1]; ex[j-1] = t;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                int idx;
                idx = f * N + i;
                if (idx < n_out) begin
                    chk(out_keys[idx] == ex[i], req, int'(out_keys[idx]), int'(ex[i]));
                    chk(out_lst[idx] == (i == N - 1), "R4 out_last",
                        int'(out_lst[idx]), int'(i == N - 1));
                end
            end
        end
        if (tp && n_out == nfr * N) begin
            for (int i = 1; i < n_out; i++)
                chk(out_cyc[i] == out_cyc[0] + i, "R5 gap-free output",
                    out_cyc[i] - out_cyc[0], i);
        end
        if (lat && n_out > 0)
            chk(out_cyc[0] - in_cyc[0] == LAT, "R6 latency", out_cyc[0] - in_cyc[0], LAT);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #2;
        chk(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_ascending();
        drive(2, 0, 1'b0);
        check_run(2, "R2 ascending input", 1'b1, 1'b1);
    endtask

    task automatic test_descending();
        drive(3, 1, 1'b0);
        check_run(3, "R2 descending input", 1'b1, 1'b1);
    endtask

    task automatic test_scattered();
        drive(4, 2, 1'b0);
        check_run(4, "R2 scattered input", 1'b1, 1'b1);
    endtask

    task automatic test_ties();
        drive(2, 3, 1'b0);
        check_run(2, "R3 stable ties", 1'b1, 1'b1);
    endtask

    task automatic test_bubbles();
        drive(3, 2, 1'b1);
        check_run(3, "R7 idle gaps", 1'b0, 1'b0);
        chk(in_ready == 1'b1, "R1 ready held", int'(in_ready), 1);
    endtask

    initial begin
        test_reset();
        test_ascending();
        test_descending();
        test_scattered();
        test_ties();
        test_bubbles();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule